// File: doc/BRIEF.md
# Decoder-Sharing Wordline Shifter

This block serves two neighbouring projection-data memories in a backprojection engine with a single row decoder. The reference memory's read address is decoded into a pair of adjacent active wordlines, so one read returns two consecutive elements, the pair that linear interpolation needs. The second memory has no decoder. Its wordlines are taken from the reference wordlines through a per-row stage of AND and OR gates. One control bit selects whether that stage passes the reference wordlines straight through or moves them down by one row.

The control bit is computed from the two row addresses. When the addresses are equal, the wordlines pass unchanged. When the second address is one row below the reference, they are shifted. Any other difference cannot be served by the shared decoder. In that case the block raises an error flag and drives the second memory with the reference wordlines unchanged.

Each memory reads out its element pair one cycle after the read request. A shared write port fills either memory, one row at a time.

Top module: `wl_share_top`

## Requirements
- R1: While reset is active and after it is released, rd_valid, shift_ct, range_err and all four read words are zero until the first read completes.
- R2: With rd_en high and ref_row at most NROW-2, ref_wl has exactly bits ref_row and ref_row+1 set. With rd_en low, both wordline vectors are all zero.
- R3: When sec_row+1 equals ref_row, the registered shift_ct is 1 and range_err is 0. sec_wl then has bits ref_row-1 and ref_row set, which is the reference pair moved one position toward index 0.
- R4: When sec_row equals ref_row, the registered shift_ct is 0 and range_err is 0, and sec_wl equals ref_wl.
- R5: For any other difference (including sec_row above ref_row, or sec_row two or more below it), range_err is 1 and shift_ct is 0 on the following cycle. sec_wl equals ref_wl in that case.
- R6: One cycle after a read, rd_valid is 1. ref_lo and ref_hi hold the reference memory's words at the lower and upper active rows of ref_wl. sec_lo and sec_hi hold the second memory's words at the lower and upper active rows of sec_wl.
- R7: At ref_row = NROW-1 only the top reference wordline is active. The shifted second vector then has only bit NROW-2 set, because the missing wordline above the top row counts as zero. Without an adjacent active pair, a memory's two read words are zero.
- R8: In a cycle without rd_en, rd_valid falls to 0 and the read words, shift_ct and range_err keep their values.
- R9: With wr_en high, wr_data is stored at row wr_row of the reference memory (wr_sel = 0) or of the second memory (wr_sel = 1). A read of the same row in the same cycle returns the old word, and the next read returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 reference memory, 1 second memory |
| wr_row | input | ROW_W | Write row |
| wr_data | input | DW | Write word |
| rd_en | input | 1 | Read request; enables the shared decoder |
| ref_row | input | ROW_W | Reference memory row (lower element of the pair) |
| sec_row | input | ROW_W | Second memory row (lower element of the pair) |
| ref_wl | output | NROW | Decoded reference wordlines |
| sec_wl | output | NROW | Derived second-memory wordlines |
| rd_valid | output | 1 | Read words updated this cycle |
| ref_lo | output | DW | Reference memory, lower element |
| ref_hi | output | DW | Reference memory, upper element |
| sec_lo | output | DW | Second memory, lower element |
| sec_hi | output | DW | Second memory, upper element |
| shift_ct | output | 1 | Registered shift control of the last read |
| range_err | output | 1 | Registered out-of-range flag of the last read |

## Verification
Two functions can occur in the same cycle: a write through the shared port and a read that activates the row being written. The bench provokes this by writing a fresh word into a row of the reference memory while a read covering that row is issued in the same cycle. It requires that this read returns the previous word and that the next read of the row returns the new one. A second overlap is an out-of-range address pair arriving together with a read. The bench checks that the flag and the fallback to unshifted wordlines show up together, and that the second memory's words come from the reference rows.

// File: rtl/wl_share_pkg.sv
package wl_share_pkg;

  typedef enum logic {
    MEM_REF = 1'b0,
    MEM_SEC = 1'b1
  } mem_sel_e;

endpackage

// File: rtl/wl_pair_decoder.sv
module wl_pair_decoder #(
  parameter int ROW_W = 4,
  parameter int NROW  = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             en,
  input  logic [ROW_W-1:0] row,
  output logic [NROW-1:0]  wl
);

  // each wordline answers for its own row and for the row just below it
  for (genvar i = 0; i < NROW; i++) begin : g_line
    if (i == 0) begin : g_bottom
      assign wl[i] = en & (row == ROW_W'(i));
    end else begin : g_upper
      assign wl[i] = en & ((row == ROW_W'(i)) | (row == ROW_W'(i - 1)));
    end
  end

  assert_ref_pair_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && (row <= ROW_W'(NROW - 2))) |->
      ($countones(wl) == 2 && wl[row] && wl[row + 1'b1]));

  assert_idle_dark_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |-> (wl == '0));

endmodule

// File: rtl/wl_shift_ctl.sv
module wl_shift_ctl #(
  parameter int ROW_W = 4
) (
  input  logic [ROW_W-1:0] ref_row,
  input  logic [ROW_W-1:0] sec_row,
  output logic             ct,
  output logic             err
);

  logic [ROW_W:0] sec_up;
  logic           same_row;
  logic           one_below;

  always_comb begin
    sec_up    = {1'b0, sec_row} + 1'b1;
    same_row  = (sec_row == ref_row);
    one_below = (sec_up == {1'b0, ref_row});
    ct        = one_below;
    err       = !(same_row || one_below);
  end

endmodule

// File: rtl/wl_shifter.sv
module wl_shifter #(
  parameter int NROW = 16
) (
  input  logic            ct,
  input  logic [NROW-1:0] a_wl,
  output logic [NROW-1:0] b_wl
);

  // per-row AND/OR configuration cell; the row above the top is tied low
  for (genvar i = 0; i < NROW; i++) begin : g_cell
    if (i == NROW - 1) begin : g_top
      assign b_wl[i] = ~ct & a_wl[i];
    end else begin : g_mid
      assign b_wl[i] = (~ct & a_wl[i]) | (ct & a_wl[i+1]);
    end
  end

  always_comb begin
    if (ct) begin
      assert_top_dark_R7: assert (!b_wl[NROW-1]);
    end
  end

endmodule

// File: rtl/wl_pair_bank.sv
module wl_pair_bank #(
  parameter int ROW_W = 4,
  parameter int NROW  = 1 << ROW_W,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [NROW-1:0]  wl,
  output logic [DW-1:0]    rd_lo,
  output logic [DW-1:0]    rd_hi
);

  logic [DW-1:0] mem_q [NROW];
  logic [DW-1:0] lo_c, hi_c;
  logic [DW-1:0] lo_d, hi_d;
  logic [DW-1:0] lo_q, hi_q;

  // storage rows carry no reset
  for (genvar i = 0; i < NROW; i++) begin : g_row
    logic row_we;
    assign row_we = wr_en & (wr_row == ROW_W'(i));
    always_ff @(posedge clk) begin
      if (row_we) begin
        mem_q[i] <= wr_data;
      end
    end
  end

  // a row joins the output only when its wordline forms an adjacent pair
  always_comb begin
    lo_c = '0;
    hi_c = '0;
    for (int i = 0; i < NROW - 1; i++) begin
      if (wl[i] && wl[i+1]) begin
        lo_c = lo_c | mem_q[i];
        hi_c = hi_c | mem_q[i+1];
      end
    end
  end

  always_comb begin
    lo_d = rd_en ? lo_c : lo_q;
    hi_d = rd_en ? hi_c : hi_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign rd_lo = lo_q;
  assign rd_hi = hi_q;

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> ($stable(rd_lo) && $stable(rd_hi)));

endmodule

// File: rtl/wl_share_top.sv
module wl_share_top
  import wl_share_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int DW    = 16,
  localparam int NROW = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] ref_row,
  input  logic [ROW_W-1:0] sec_row,
  output logic [NROW-1:0]  ref_wl,
  output logic [NROW-1:0]  sec_wl,
  output logic             rd_valid,
  output logic [DW-1:0]    ref_lo,
  output logic [DW-1:0]    ref_hi,
  output logic [DW-1:0]    sec_lo,
  output logic [DW-1:0]    sec_hi,
  output logic             shift_ct,
  output logic             range_err
);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  logic ct_c, err_c;
  logic wr_ref, wr_sec;

  assign wr_ref = wr_en & (mem_sel_e'(wr_sel) == MEM_REF);
  assign wr_sec = wr_en & (mem_sel_e'(wr_sel) == MEM_SEC);

  wl_shift_ctl #(.ROW_W(ROW_W)) i_ctl (
    .ref_row (ref_row),
    .sec_row (sec_row),
    .ct      (ct_c),
    .err     (err_c)
  );

  wl_pair_decoder #(.ROW_W(ROW_W), .NROW(NROW)) i_dec (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en     (rd_en),
    .row    (ref_row),
    .wl     (ref_wl)
  );

  wl_shifter #(.NROW(NROW)) i_shift (
    .ct   (ct_c),
    .a_wl (ref_wl),
    .b_wl (sec_wl)
  );

  wl_pair_bank #(.ROW_W(ROW_W), .NROW(NROW), .DW(DW)) i_bank_ref (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (wr_ref),
    .wr_row  (wr_row),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .wl      (ref_wl),
    .rd_lo   (ref_lo),
    .rd_hi   (ref_hi)
  );

  wl_pair_bank #(.ROW_W(ROW_W), .NROW(NROW), .DW(DW)) i_bank_sec (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (wr_sec),
    .wr_row  (wr_row),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .wl      (sec_wl),
    .rd_lo   (sec_lo),
    .rd_hi   (sec_hi)
  );

  // status registers: next-state then register
  logic valid_d, ct_d, err_d;
  logic valid_q, ct_q, err_q;

  always_comb begin
    valid_d = rd_en;
    ct_d    = rd_en ? ct_c  : ct_q;
    err_d   = rd_en ? err_c : err_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ct_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ct_q    <= ct_d;
      err_q   <= err_d;
    end
  end

  assign rd_valid  = valid_q;
  assign shift_ct  = ct_q;
  assign range_err = err_q;

  assert_shift_pair_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && (sec_row + 1'b1 == ref_row) && ref_row != '0 &&
     ref_row <= ROW_W'(NROW - 2)) |->
      ($countones(sec_wl) == 2 && sec_wl[sec_row] && sec_wl[ref_row]));

  assert_same_pair_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && sec_row == ref_row) |-> (sec_wl == ref_wl));

  assert_flag_fallback_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && sec_row != ref_row && (sec_row + 1'b1 != ref_row || ref_row == '0))
      |-> (sec_wl == ref_wl) ##1 (range_err && !shift_ct));

  assert_ct_err_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !(shift_ct && range_err));

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_en |=> rd_valid);

  assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> (!rd_valid && $stable(shift_ct) && $stable(range_err)));

endmodule

// File: tb/test_wl_share_top.sv
module test_wl_share_top;

  localparam int ROW_W  = 4;
  localparam int DW     = 16;
  localparam int NROW   = 1 << ROW_W;
  localparam int CLK_PD = 10;
  localparam int NVEC   = 12;

  // each entry: {ref_row, sec_row}
  localparam logic [7:0] VEC [NVEC] = '{
    {4'd5, 4'd5}, {4'd5, 4'd4}, {4'd5, 4'd6}, {4'd5, 4'd3},
    {4'd0, 4'd0}, {4'd1, 4'd0}, {4'd0, 4'd15}, {4'd14, 4'd14},
    {4'd14, 4'd13}, {4'd7, 4'd12}, {4'd9, 4'd8}, {4'd2, 4'd2}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en, wr_sel, rd_en;
  logic [ROW_W-1:0] wr_row, ref_row, sec_row;
  logic [DW-1:0]    wr_data;
  logic [NROW-1:0]  ref_wl, sec_wl;
  logic             rd_valid, shift_ct, range_err;
  logic [DW-1:0]    ref_lo, ref_hi, sec_lo, sec_hi;

  logic [DW-1:0] mdl_a [NROW];
  logic [DW-1:0] mdl_b [NROW];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PD/2) clk = ~clk;

  wl_share_top #(.ROW_W(ROW_W), .DW(DW)) i_wl_share_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_row(wr_row), .wr_data(wr_data), .rd_en(rd_en),
    .ref_row(ref_row), .sec_row(sec_row), .ref_wl(ref_wl), .sec_wl(sec_wl),
    .rd_valid(rd_valid), .ref_lo(ref_lo), .ref_hi(ref_hi),
    .sec_lo(sec_lo), .sec_hi(sec_hi), .shift_ct(shift_ct),
    .range_err(range_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NROW-1:0] pair_wl(input int r);
    logic [NROW-1:0] v = '0;
    v[r] = 1'b1;
    if (r + 1 < NROW) v[r+1] = 1'b1;
    return v;
  endfunction

  function automatic bit is_pair(input logic [NROW-1:0] v);
    return ($countones(v) == 2) && ($countones(v & (v >> 1)) == 1);
  endfunction

  task automatic write_row(input bit sel, input int r, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_row = ROW_W'(r); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel) mdl_b[r] = d; else mdl_a[r] = d;
  endtask

  // issue one read and check wordlines, then registered outputs
  task automatic do_read(input int r, input int s);
    int exp_ct, exp_err, lo_row;
    logic [NROW-1:0] e_ref, e_sec;
    logic [DW-1:0] e_rl, e_rh, e_sl, e_sh;
    exp_ct  = (s + 1 == r) ? 1 : 0;
    exp_err = (s == r || s + 1 == r) ? 0 : 1;
    e_ref = pair_wl(r);
    e_sec = exp_ct ? pair_wl(r - 1) : e_ref;
    if (exp_ct && r == NROW - 1) e_sec = '0 | (NROW'(1) << (NROW - 2));
    @(negedge clk);
    rd_en = 1'b1; ref_row = ROW_W'(r); sec_row = ROW_W'(s);
    #1;
    chk(ref_wl == e_ref, "R2 ref_wl", 64'(ref_wl), 64'(e_ref));
    if (r <= NROW - 2) chk(is_pair(ref_wl), "R2 ref pair shape", 64'(ref_wl), 64'(e_ref));
    if (exp_ct == 1)
      chk(sec_wl == e_sec, "R3 shifted sec_wl", 64'(sec_wl), 64'(e_sec));
    else if (exp_err == 0)
      chk(sec_wl == e_sec, "R4 same sec_wl", 64'(sec_wl), 64'(e_sec));
    else
      chk(sec_wl == e_sec, "R5 fallback sec_wl", 64'(sec_wl), 64'(e_sec));
    if (r <= NROW - 2) chk(is_pair(sec_wl), "R3 sec pair shape", 64'(sec_wl), 64'(e_sec));
    e_rl = '0; e_rh = '0; e_sl = '0; e_sh = '0;
    if (r <= NROW - 2) begin e_rl = mdl_a[r]; e_rh = mdl_a[r+1]; end
    lo_row = exp_ct ? r - 1 : r;
    if (lo_row <= NROW - 2 && !(exp_ct && r == NROW - 1)) begin
      e_sl = mdl_b[lo_row]; e_sh = mdl_b[lo_row+1];
    end
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b1, "R6 rd_valid", 64'(rd_valid), 64'd1);
    chk(shift_ct == 1'(exp_ct), "R3 shift_ct", 64'(shift_ct), 64'(exp_ct));
    chk(range_err == 1'(exp_err), "R5 range_err", 64'(range_err), 64'(exp_err));
    chk({ref_lo, ref_hi} == {e_rl, e_rh}, "R6 ref pair data",
        64'({ref_lo, ref_hi}), 64'({e_rl, e_rh}));
    chk({sec_lo, sec_hi} == {e_sl, e_sh}, "R6 sec pair data",
        64'({sec_lo, sec_hi}), 64'({e_sl, e_sh}));
  endtask

  initial begin
    #(CLK_PD * 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] h_lo, h_hi;
    logic h_ct, h_err;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; rd_en = 1'b0;
    wr_row = '0; ref_row = '0; sec_row = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk({rd_valid, shift_ct, range_err} == 3'b000, "R1 status in reset",
        64'({rd_valid, shift_ct, range_err}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({ref_lo, ref_hi, sec_lo, sec_hi} == '0, "R1 data after reset",
        64'(ref_lo), 64'd0);
    chk(ref_wl == '0 && sec_wl == '0, "R2 idle wordlines dark",
        64'({ref_wl, sec_wl}), 64'd0);

    for (int i = 0; i < NROW; i++) begin
      write_row(1'b0, i, DW'(16'hA000 + i));
      write_row(1'b1, i, DW'(16'hB000 + i));
    end

    for (int k = 0; k < NVEC; k++) begin
      do_read(int'(VEC[k][7:4]), int'(VEC[k][3:0]));
    end

    // R7: top row, equal and shifted second address
    do_read(NROW - 1, NROW - 1);
    do_read(NROW - 1, NROW - 2);

    // R8: idle cycle holds everything except rd_valid
    do_read(6, 5);
    h_lo = sec_lo; h_hi = ref_hi; h_ct = shift_ct; h_err = range_err;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8 rd_valid low", 64'(rd_valid), 64'd0);
    chk(sec_lo == h_lo && ref_hi == h_hi && shift_ct == h_ct && range_err == h_err,
        "R8 hold", 64'({sec_lo, ref_hi}), 64'({h_lo, h_hi}));

    // R9: write and read of the same row in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_row = 4'd3; wr_data = 16'h1234;
    rd_en = 1'b1; ref_row = 4'd3; sec_row = 4'd3;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(ref_lo == mdl_a[3], "R9 old word on colliding read", 64'(ref_lo), 64'(mdl_a[3]));
    mdl_a[3] = 16'h1234;
    do_read(3, 3);
    write_row(1'b1, 9, 16'h5A5A);
    do_read(9, 9);
    chk(sec_lo == 16'h5A5A && ref_lo == mdl_a[9], "R9 second memory write",
        64'({sec_lo, ref_lo}), 64'({16'h5A5A, mdl_a[9]}));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule